// File: doc/BRIEF.md
# Host-to-Local Bus Slave Bridge

This block lets a synchronous host bus reach slow peripherals on a narrow local bus, such as a boot memory or the control registers of a line-interface device. A host request whose upper address bits match a configured window is captured. The block then drives a local address, data word and active-low strobes, and waits for the addressed device to raise its ready line.

Every local access is bounded by a fixed cycle limit, eight host cycles by default. The access ends either on ready or on that limit. The host receives a one-cycle acknowledge only once the local side has finished, so the host must keep its address stable until then.

A flag records whether the most recent access ended on the limit instead of on ready. The local interrupt line is forwarded to the host independently of any access.

Top module: `hlb_bridge`

## Requirements
- R1: After reset, all three local strobes are high (inactive), `host_ack` is 0 and `host_timeout` is 0.
- R2: A request (`host_sel`=1) is accepted only when `host_addr[AW-1:LAW]` equals `WIN_BASE`. Any other address leaves the strobes inactive and produces no acknowledge.
- R3: `lcl_addr` equals the low `LAW` bits of the accepted host address and stays stable while `lcl_cs_n` is low.
- R4: An accepted request drives `lcl_cs_n` low at the accepting edge. A read (`host_rd`=1) drives `lcl_oe_n` low and keeps `lcl_we_n` high. A write does the opposite and holds the captured write data on `lcl_wdata` for the whole access.
- R5: If `lcl_ready` is sampled high at the k-th clock edge after the accepting edge (k from 1 to `LIMIT`), the strobes stay low for exactly k cycles. The acknowledge is high in the cycle that follows.
- R6: If ready never comes, the strobes are released and the acknowledge is raised after exactly `LIMIT` cycles.
- R7: `host_ack` is high for exactly one cycle per access, with the strobes already released. On a read, `host_rdata` then holds the value `lcl_rdata` had at the terminating edge.
- R8: `host_timeout` is set to 1 when an access ends on the limit. It is set to 0 when the access ends on ready, including ready at the limit edge itself. It holds its value until the next access ends.
- R9: A request present during the acknowledge cycle is not accepted. The cycle after the acknowledge always has the strobes inactive.
- R10: `host_irq` equals `lcl_irq` delayed by one clock cycle, whatever the access state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host request, held until acknowledge |
| host_rd | input | 1 | 1 = read, 0 = write |
| host_addr | input | AW | Host address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Read data, valid with `host_ack` |
| host_ack | output | 1 | One-cycle access acknowledge |
| host_timeout | output | 1 | Last access ended on the cycle limit |
| host_irq | output | 1 | Forwarded local interrupt |
| lcl_addr | output | LAW | Local address |
| lcl_wdata | output | DW | Local write data |
| lcl_rdata | input | DW | Local read data |
| lcl_cs_n | output | 1 | Local chip select, active low |
| lcl_oe_n | output | 1 | Local output enable, active low |
| lcl_we_n | output | 1 | Local write enable, active low |
| lcl_ready | input | 1 | Completion handshake from the device |
| lcl_irq | input | 1 | Local interrupt request |

## Verification
The hardest case to reach is ready arriving on the very edge where the cycle limit also expires. On that edge the two termination causes coincide, and the flag must credit ready. The stimulus reaches it by counting, at each falling edge, how many cycles the chip select has been low. It raises ready exactly when that count reaches a chosen k, and sweeps k over every value from 1 to the limit and also over "never", for both reads and writes. The read data presented to the device changes with that count, so the value returned to the host identifies the edge on which it was latched.

// File: rtl/hlb_pkg.sv
package hlb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_WAIT  = 2'd2,
    ST_ACK   = 2'd3
  } hlb_state_e;
endpackage

// File: rtl/hlb_decode.sv
module hlb_decode #(
  parameter int AW = 24,
  parameter int LAW = 16,
  parameter logic [AW-LAW-1:0] WIN_BASE = '1
) (
  input  logic          sel,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  always_comb hit = sel && (addr[AW-1:LAW] == WIN_BASE);
endmodule

// File: rtl/hlb_timer.sv
module hlb_timer #(
  parameter int LIMIT = 8,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          run,
  output logic [CW-1:0] cnt,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (run && cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
  end

  always_comb last = (cnt == CW'(LIMIT - 1));

  a_r6_cnt_saturates: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(LIMIT));
endmodule

// File: rtl/hlb_bridge.sv
module hlb_bridge #(
  parameter int AW = 24,
  parameter int LAW = 16,
  parameter int DW = 16,
  parameter int LIMIT = 8,
  parameter logic [AW-LAW-1:0] WIN_BASE = 8'hA5,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           host_sel,
  input  logic           host_rd,
  input  logic [AW-1:0]  host_addr,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  output logic           host_ack,
  output logic           host_timeout,
  output logic           host_irq,
  output logic [LAW-1:0] lcl_addr,
  output logic [DW-1:0]  lcl_wdata,
  input  logic [DW-1:0]  lcl_rdata,
  output logic           lcl_cs_n,
  output logic           lcl_oe_n,
  output logic           lcl_we_n,
  input  logic           lcl_ready,
  input  logic           lcl_irq
);
  import hlb_pkg::*;

  hlb_state_e    state;
  logic          hit, start, active, finish, is_rd, tmr_last;
  logic [CW-1:0] tmr_cnt;

  hlb_decode #(.AW(AW), .LAW(LAW), .WIN_BASE(WIN_BASE)) u_dec (
    .sel(host_sel), .addr(host_addr), .hit(hit)
  );

  always_comb begin
    start  = (state == ST_IDLE) && hit;
    active = (state == ST_SETUP) || (state == ST_WAIT);
    finish = active && (lcl_ready || tmr_last);
  end

  hlb_timer #(.LIMIT(LIMIT)) u_tmr (
    .clk(clk), .rst(rst), .clear(start), .run(active),
    .cnt(tmr_cnt), .last(tmr_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      lcl_cs_n     <= 1'b1;
      lcl_oe_n     <= 1'b1;
      lcl_we_n     <= 1'b1;
      lcl_addr     <= '0;
      lcl_wdata    <= '0;
      host_rdata   <= '0;
      host_ack     <= 1'b0;
      host_timeout <= 1'b0;
      host_irq     <= 1'b0;
      is_rd        <= 1'b0;
    end else begin
      host_irq <= lcl_irq;
      host_ack <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_SETUP;
          is_rd    <= host_rd;
          lcl_addr <= host_addr[LAW-1:0];
          if (!host_rd) lcl_wdata <= host_wdata;
          lcl_cs_n <= 1'b0;
          lcl_oe_n <= !host_rd;
          lcl_we_n <= host_rd;
        end
        ST_SETUP, ST_WAIT: begin
          if (finish) begin
            state        <= ST_ACK;
            lcl_cs_n     <= 1'b1;
            lcl_oe_n     <= 1'b1;
            lcl_we_n     <= 1'b1;
            host_ack     <= 1'b1;
            host_timeout <= !lcl_ready;
            if (is_rd) host_rdata <= lcl_rdata;
          end else begin
            state <= ST_WAIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!lcl_oe_n && !lcl_we_n));
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!lcl_cs_n && !$past(lcl_cs_n)) |-> $stable(lcl_addr));
  a_r6_limit_bound: assert property (@(posedge clk) disable iff (rst)
    !lcl_cs_n |-> (tmr_cnt < CW'(LIMIT)));
  a_r7_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !host_ack);
  a_r7_ack_released: assert property (@(posedge clk) disable iff (rst)
    host_ack |-> lcl_cs_n);
  a_r9_idle_gap: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> lcl_cs_n);
  a_r8_timeout_at_limit: assert property (@(posedge clk) disable iff (rst)
    (host_ack && host_timeout) |-> ($past(tmr_cnt) == CW'(LIMIT - 1)));
endmodule

// File: tb/hlb_bridge_test.sv
module hlb_bridge_test;
  localparam int AW = 24, LAW = 16, DW = 16, LIMIT = 8;
  localparam logic [7:0] WIN = 8'hA5;

  logic clk = 0, rst = 1;
  logic host_sel = 0, host_rd = 0, lcl_ready = 0, lcl_irq = 0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0, lcl_rdata = '0;
  logic [DW-1:0] host_rdata, lcl_wdata;
  logic [LAW-1:0] lcl_addr;
  logic host_ack, host_timeout, host_irq, lcl_cs_n, lcl_oe_n, lcl_we_n;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  hlb_bridge #(.AW(AW), .LAW(LAW), .DW(DW), .LIMIT(LIMIT), .WIN_BASE(WIN)) uut (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ack(host_ack), .host_timeout(host_timeout), .host_irq(host_irq),
    .lcl_addr(lcl_addr), .lcl_wdata(lcl_wdata), .lcl_rdata(lcl_rdata),
    .lcl_cs_n(lcl_cs_n), .lcl_oe_n(lcl_oe_n), .lcl_we_n(lcl_we_n),
    .lcl_ready(lcl_ready), .lcl_irq(lcl_irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // rdy_at: 1..LIMIT raises ready after that many strobe cycles, 0 means never
  task automatic access(input bit rd, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                        input int rdy_at, input logic [DW-1:0] pat);
    int act = 0;
    bit got = 0;
    int exp_len = (rdy_at == 0) ? LIMIT : rdy_at;
    @(negedge clk);
    host_sel = 1; host_rd = rd; host_addr = addr; host_wdata = wd;
    lcl_rdata = pat; lcl_ready = 0;
    for (int i = 0; i < 20 && !got; i++) begin
      @(negedge clk);
      if (host_ack) got = 1;
      else if (!lcl_cs_n) begin
        act++;
        host_wdata = ~wd;
        chk(lcl_addr == addr[LAW-1:0], "R3 local address", lcl_addr, addr[LAW-1:0]);
        chk(lcl_oe_n == !rd && lcl_we_n == rd, "R4 strobe select",
            {lcl_oe_n, lcl_we_n}, {!rd, rd});
        if (!rd) chk(lcl_wdata == wd, "R4 write data held", lcl_wdata, wd);
        lcl_rdata = pat ^ DW'(act);
        if (rdy_at != 0 && act == rdy_at) lcl_ready = 1;
      end
    end
    chk(got, "R5/R6 acknowledge seen", got, 1);
    chk(act == exp_len, rdy_at == 0 ? "R6 limit length" : "R5 ready length", act, exp_len);
    chk(lcl_cs_n && lcl_oe_n && lcl_we_n, "R7 strobes released at ack",
        {lcl_cs_n, lcl_oe_n, lcl_we_n}, 3'b111);
    if (rd) chk(host_rdata == (pat ^ DW'(exp_len)), "R7 read data", host_rdata, pat ^ DW'(exp_len));
    chk(host_timeout == (rdy_at == 0), "R8 timeout flag", host_timeout, rdy_at == 0);
    lcl_ready = 0;
    @(negedge clk);
    chk(!host_ack, "R7 single-cycle ack", host_ack, 0);
    chk(lcl_cs_n, "R9 no accept in ack cycle", lcl_cs_n, 1);
    chk(host_timeout == (rdy_at == 0), "R8 flag held", host_timeout, rdy_at == 0);
    host_sel = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(lcl_cs_n && lcl_oe_n && lcl_we_n, "R1 reset strobes", {lcl_cs_n, lcl_oe_n, lcl_we_n}, 3'b111);
    chk(!host_ack && !host_timeout, "R1 reset ack/flag", {host_ack, host_timeout}, 0);
    rst = 0;

    // R10 interrupt forwarding
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(host_irq == lcl_irq, "R10 irq delay", host_irq, lcl_irq);
      lcl_irq = i[0] ^ i[2];
    end

    // R2 outside window ignored
    @(negedge clk);
    host_sel = 1; host_rd = 1; host_addr = {8'h5A, 16'h1234};
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(lcl_cs_n && !host_ack, "R2 outside window ignored", {lcl_cs_n, host_ack}, 2'b10);
    end
    host_sel = 0;

    // R5/R6/R8 sweep over ready position, both directions
    for (int rd = 0; rd < 2; rd++)
      for (int k = 0; k <= LIMIT; k++)
        access(rd[0], {WIN, 16'(16'h1000 * k + rd * 16'h0101)}, 16'(16'hC3A0 + k),
               k, 16'(16'h7700 ^ (k << 8)));

    // interleave: limit then ready, flag must clear
    access(1'b1, {WIN, 16'hFFFF}, 16'h0, 0, 16'hABC0);
    access(1'b0, {WIN, 16'h0000}, 16'h5555, 3, 16'h0);

    // R10 during an access
    fork
      access(1'b1, {WIN, 16'h4242}, 16'h0, 0, 16'h1110);
      begin
        for (int i = 0; i < 6; i++) begin
          @(negedge clk);
          chk(host_irq == lcl_irq, "R10 irq during access", host_irq, lcl_irq);
          lcl_irq = ~lcl_irq;
        end
      end
    join

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule